// File: doc/BRIEF.md
# E1 Transmit Payload Timing Generator

This block produces the transmit-side timing for a single E1 port. It runs in a fast system clock domain and advances once per bit whenever the bit-rate enable `bit_en_i` is high. That enable is nominally 2.048 MHz, one bit per pulse. It counts bits within a timeslot, timeslots within a 256-bit frame, and frames within a 16-frame multiframe. From that position it drives a 5-bit identifier bus, a serial clock enable, and a signaling pass-through.

In normal operation the identifier bus carries the current timeslot number. The serial clock enable either follows every bit or is gapped, so that it pulses only for payload bits (timeslots 1 to 31). Timeslot 0 is overhead. A fractional mode reuses the identifier bus:

- bit 0 becomes a signaling input;
- bit 1 becomes a fractional data input;
- bit 2 becomes a fast clock output;
- bit 3 becomes a marker that is high for the first bit of each multiframe.

Fractional data bits are captured either on the rising edge of a per-channel clock, or on serial bit enables qualified by that channel clock. Each accepted bit is presented on a data-plus-valid output. A high-speed or multiplexed mode overrides the fractional enable and keeps identifier bit 0 as the signaling input.

Top module: `e1_tx_timing`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the position is bit 0 of timeslot 0 of frame 0. All control shadows are 0, `ts_id_o` reads 0 and `frac_valid_o` is 0.
- R2: Each cycle with `bit_en_i` high advances the position by one bit. There are 8 bits per timeslot, 32 timeslots per frame and 16 frames per multiframe, each wrapping to 0. In normal mode (fractional shadow 0, high-speed shadow 0), `ts_id_o` equals the current timeslot number.
- R3: With the gap shadow at 0, `ser_clk_en_o` equals `bit_en_i` in every cycle.
- R4: With the gap shadow at 1, `ser_clk_en_o` is `bit_en_i` during timeslots 1 to 31 and 0 throughout timeslot 0.
- R5: In fractional mode (fractional shadow 1, high-speed shadow 0), `ts_id_o` bits 0, 1 and 4 read 0. Bit 2 carries the fast clock and bit 3 carries the multiframe marker.
- R6: The multiframe marker on `ts_id_o[3]` in fractional mode is 1 exactly while the position is bit 0 of timeslot 0 of frame 0. That is once per 4096 bits.
- R7: The fast clock on `ts_id_o[2]` runs freely from reset with a period of FAST_DIV system clocks (default 8). It is high for the first FAST_DIV/2 clocks of each period.
- R8: In fractional mode with sync-select shadow 0, a bit of `frac_data_i` is captured in any cycle where `chan_clk_i` is 1 and was 0 in the previous cycle. The next cycle shows `frac_valid_o`=1 and `frac_data_o` equal to the captured bit.
- R9: In fractional mode with sync-select shadow 1, a bit is captured in any cycle where `bit_en_i` and `chan_clk_i` are both 1. It is presented the same way. No capture happens outside fractional mode.
- R10: With the high-speed shadow at 1, the fractional shadow has no effect. `ts_id_o` shows the timeslot number with bit 0 forced to 0, `sig_o` follows `sig_i`, and no fractional capture occurs.
- R11: The control inputs `frac_en_i`, `frac_sync_i`, `gap_en_i` and `hs_mode_i` are copied into their shadows only on the bit enable that ends a frame (timeslot 31, bit 7). A change mid-frame has no visible effect until then.
- R12: `sig_o` is 0 in normal mode, and follows `sig_i` whenever identifier bit 0 acts as the signaling input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle pulse per E1 bit |
| frac_en_i | input | 1 | Fractional mode request |
| frac_sync_i | input | 1 | Capture scheme: 0 channel-clock edge, 1 bit enable qualified by channel clock |
| gap_en_i | input | 1 | Suppress serial clock enable in overhead timeslot |
| hs_mode_i | input | 1 | High-speed or multiplexed operation |
| chan_clk_i | input | 1 | Per-channel clock / data enable |
| frac_data_i | input | 1 | Fractional data input (identifier bit 1 role) |
| sig_i | input | 1 | Serial signaling input (identifier bit 0 role) |
| ts_id_o | output | 5 | Timeslot number or remapped functions |
| ser_clk_en_o | output | 1 | Serial clock enable, optionally gapped |
| sig_o | output | 1 | Routed signaling bit |
| frac_data_o | output | 1 | Captured fractional bit |
| frac_valid_o | output | 1 | Captured bit valid, one cycle per capture |

## Verification
The bench changes controls mid-frame and checks that the outputs keep their old mapping until the frame ends. A design that sampled controls immediately would show torn frames with a wrong identifier or gap. It runs through whole multiframes in fractional mode so that the marker is checked at the 4096-bit wrap. An off-by-one frame or timeslot counter would move or repeat that pulse. The channel clock is driven randomly under both capture schemes. This exposes a design that captures on a level instead of an edge, or that ignores the bit-enable qualifier. High-speed mode with the fractional request held on catches a design that lets the fractional mapping through. Irregular bit enables expose counters that advance without an enable.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;
  typedef struct packed {
    logic frac_en;
    logic frac_sync;
    logic gap_en;
    logic hs_mode;
  } tx_ctrl_t;
endpackage

// File: rtl/e1_tx_bit_counter.sv
module e1_tx_bit_counter #(
  parameter int BITS_PER_TS   = 8,
  parameter int TS_PER_FRAME  = 32,
  parameter int FRAMES_PER_MF = 16,
  localparam int BIT_W = $clog2(BITS_PER_TS),
  localparam int TS_W  = $clog2(TS_PER_FRAME),
  localparam int FR_W  = $clog2(FRAMES_PER_MF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  output logic [BIT_W-1:0] bit_o,
  output logic [TS_W-1:0]  ts_o,
  output logic [FR_W-1:0]  fr_o,
  output logic            frame_end_o,
  output logic            mf_first_o
);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(BITS_PER_TS - 1);
  localparam logic [TS_W-1:0]  TS_MAX  = TS_W'(TS_PER_FRAME - 1);
  localparam logic [FR_W-1:0]  FR_MAX  = FR_W'(FRAMES_PER_MF - 1);

  logic [BIT_W-1:0] bit_q;
  logic [TS_W-1:0]  ts_q;
  logic [FR_W-1:0]  fr_q;
  logic ts_end, fr_end;

  assign ts_end = bit_en_i && (bit_q == BIT_MAX);
  assign fr_end = ts_end && (ts_q == TS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      ts_q  <= '0;
      fr_q  <= '0;
    end else if (bit_en_i) begin
      bit_q <= (bit_q == BIT_MAX) ? '0 : bit_q + 1'b1;
      if (ts_end) ts_q <= (ts_q == TS_MAX) ? '0 : ts_q + 1'b1;
      if (fr_end) fr_q <= (fr_q == FR_MAX) ? '0 : fr_q + 1'b1;
    end
  end

  assign bit_o       = bit_q;
  assign ts_o        = ts_q;
  assign fr_o        = fr_q;
  assign frame_end_o = fr_end;
  assign mf_first_o  = (bit_q == '0) && (ts_q == '0) && (fr_q == '0);
endmodule

// File: rtl/e1_tx_ctrl_shadow.sv
module e1_tx_ctrl_shadow
  import e1_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  tx_ctrl_t ctrl_i,
  output tx_ctrl_t ctrl_o
);
  tx_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (load_i) ctrl_q <= ctrl_i;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/e1_tx_fast_clk.sv
module e1_tx_fast_clk #(
  parameter int FAST_DIV = 8,
  localparam int CNT_W = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_clk_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] HALF    = CNT_W'(FAST_DIV / 2);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  assign fast_clk_o = (cnt_q < HALF);
endmodule

// File: rtl/e1_tx_frac_capture.sv
module e1_tx_frac_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic sync_sel_i,
  input  logic bit_en_i,
  input  logic chan_clk_i,
  input  logic data_i,
  output logic data_o,
  output logic valid_o
);
  logic chan_q, data_q, valid_q, cap;

  // sync_sel=1: serial bit enable strobes, channel clock qualifies
  assign cap = act_i && (sync_sel_i ? (bit_en_i && chan_clk_i)
                                    : (chan_clk_i && !chan_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= 1'b0;
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      chan_q  <= chan_clk_i;
      valid_q <= cap;
      if (cap) data_q <= data_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/e1_tx_timing.sv
module e1_tx_timing
  import e1_tx_pkg::*;
#(
  parameter int BITS_PER_TS   = 8,
  parameter int TS_PER_FRAME  = 32,
  parameter int FRAMES_PER_MF = 16,
  parameter int FAST_DIV      = 8,
  localparam int BIT_W = $clog2(BITS_PER_TS),
  localparam int TS_W  = $clog2(TS_PER_FRAME),
  localparam int FR_W  = $clog2(FRAMES_PER_MF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  input  logic            frac_en_i,
  input  logic            frac_sync_i,
  input  logic            gap_en_i,
  input  logic            hs_mode_i,
  input  logic            chan_clk_i,
  input  logic            frac_data_i,
  input  logic            sig_i,
  output logic [TS_W-1:0] ts_id_o,
  output logic            ser_clk_en_o,
  output logic            sig_o,
  output logic            frac_data_o,
  output logic            frac_valid_o
);
  logic [BIT_W-1:0] bit_q;
  logic [TS_W-1:0]  ts_q;
  logic [FR_W-1:0]  fr_q;
  logic frame_end, mf_first, fast_clk, frac_act, sig_act;
  tx_ctrl_t ctrl_d, ctrl_q;

  e1_tx_bit_counter #(
    .BITS_PER_TS(BITS_PER_TS), .TS_PER_FRAME(TS_PER_FRAME), .FRAMES_PER_MF(FRAMES_PER_MF)
  ) u_cnt (
    .clk_i, .rst_ni, .bit_en_i,
    .bit_o(bit_q), .ts_o(ts_q), .fr_o(fr_q),
    .frame_end_o(frame_end), .mf_first_o(mf_first)
  );

  assign ctrl_d = '{frac_en: frac_en_i, frac_sync: frac_sync_i,
                    gap_en: gap_en_i, hs_mode: hs_mode_i};

  e1_tx_ctrl_shadow u_shadow (
    .clk_i, .rst_ni, .load_i(frame_end), .ctrl_i(ctrl_d), .ctrl_o(ctrl_q)
  );

  e1_tx_fast_clk #(.FAST_DIV(FAST_DIV)) u_fast (
    .clk_i, .rst_ni, .fast_clk_o(fast_clk)
  );

  assign frac_act = ctrl_q.frac_en && !ctrl_q.hs_mode;
  assign sig_act  = frac_act || ctrl_q.hs_mode;

  e1_tx_frac_capture u_frac (
    .clk_i, .rst_ni,
    .act_i(frac_act), .sync_sel_i(ctrl_q.frac_sync),
    .bit_en_i, .chan_clk_i, .data_i(frac_data_i),
    .data_o(frac_data_o), .valid_o(frac_valid_o)
  );

  // pin function mux
  always_comb begin
    ts_id_o = ts_q;
    if (frac_act) begin
      ts_id_o    = '0;
      ts_id_o[2] = fast_clk;
      ts_id_o[3] = mf_first;
    end else if (ctrl_q.hs_mode) begin
      ts_id_o[0] = 1'b0;
    end
  end

  assign ser_clk_en_o = bit_en_i && (!ctrl_q.gap_en || (ts_q != '0));
  assign sig_o        = sig_act && sig_i;
endmodule

// File: rtl/e1_tx_timing_chk.sv
module e1_tx_timing_chk
  import e1_tx_pkg::*;
#(
  parameter int BIT_W = 3,
  parameter int TS_W  = 5,
  parameter int BITS_PER_TS  = 8,
  parameter int TS_PER_FRAME = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_en_i,
  input logic [BIT_W-1:0] bit_q,
  input logic [TS_W-1:0] ts_q,
  input tx_ctrl_t        ctrl_q,
  input logic            frame_end,
  input logic            frac_act,
  input logic            ser_clk_en_o,
  input logic            frac_valid_o
);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(BITS_PER_TS - 1);
  localparam logic [TS_W-1:0]  TS_MAX  = TS_W'(TS_PER_FRAME - 1);

  assert_ts_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && bit_q == BIT_MAX) |=>
      ts_q == (($past(ts_q) == TS_MAX) ? '0 : $past(ts_q) + 1'b1));

  assert_hold_no_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(bit_q) && $stable(ts_q)));

  assert_clk_en_needs_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_en_o |-> bit_en_i);

  assert_gap_in_overhead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.gap_en && ts_q == '0) |-> !ser_clk_en_o);

  assert_ctrl_frame_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(ctrl_q));

  assert_no_capture_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frac_act |=> !frac_valid_o);
endmodule

bind e1_tx_timing e1_tx_timing_chk #(
  .BIT_W(BIT_W), .TS_W(TS_W), .BITS_PER_TS(BITS_PER_TS), .TS_PER_FRAME(TS_PER_FRAME)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
  .bit_q(bit_q), .ts_q(ts_q), .ctrl_q(ctrl_q), .frame_end(frame_end),
  .frac_act(frac_act), .ser_clk_en_o(ser_clk_en_o), .frac_valid_o(frac_valid_o)
);

// File: tb/e1_tx_timing_tb.sv
module e1_tx_timing_tb_top;
  localparam int FD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, frac_en = 1'b0, frac_sync = 1'b0, gap_en = 1'b0, hs_mode = 1'b0;
  logic chan_clk = 1'b0, frac_d = 1'b0, sig = 1'b0;
  logic [4:0] ts_id;
  logic ser_clk_en, sig_out, frac_data, frac_valid;

  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_tx_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en),
    .frac_en_i(frac_en), .frac_sync_i(frac_sync), .gap_en_i(gap_en), .hs_mode_i(hs_mode),
    .chan_clk_i(chan_clk), .frac_data_i(frac_d), .sig_i(sig),
    .ts_id_o(ts_id), .ser_clk_en_o(ser_clk_en), .sig_o(sig_out),
    .frac_data_o(frac_data), .frac_valid_o(frac_valid)
  );

  // behavioural reference
  int pos, fcnt;
  bit m_frac, m_sync, m_gap, m_hs, m_chprev, m_v, m_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; fcnt = 0;
      m_frac = 0; m_sync = 0; m_gap = 0; m_hs = 0;
      m_chprev = 0; m_v = 0; m_d = 0;
    end else begin
      bit act, cap;
      act = m_frac && !m_hs;
      cap = act && (m_sync ? (bit_en && chan_clk) : (chan_clk && !m_chprev));
      m_v = cap;
      if (cap) m_d = frac_d;
      m_chprev = chan_clk;
      fcnt = (fcnt + 1) % FD;
      if (bit_en) begin
        if (pos % 256 == 255) begin
          m_frac = frac_en; m_sync = frac_sync; m_gap = gap_en; m_hs = hs_mode;
        end
        pos = (pos + 1) % 4096;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    int ts;
    bit act, mk, fclk;
    logic [4:0] exp_id;
    ts = (pos / 8) % 32;
    act = m_frac && !m_hs;
    mk = (pos == 0);
    fclk = (fcnt < FD / 2);
    if (act) begin
      exp_id = {1'b0, mk, fclk, 2'b00};
      chk("R5 ts_id", ts_id, exp_id);
      if (mk) chk("R6 marker", ts_id[3], 1);
      chk("R7 fast clock", ts_id[2], fclk);
    end else if (m_hs) begin
      exp_id = 5'(ts) & 5'b11110;
      chk("R10 ts_id", ts_id, exp_id);
    end else begin
      chk("R2 ts_id", ts_id, ts);
    end
    if (m_gap) chk("R4 ser_clk_en", ser_clk_en, bit_en && (ts != 0));
    else       chk("R3 ser_clk_en", ser_clk_en, bit_en);
    if (act || m_hs) chk("R10 sig_o", sig_out, sig);
    else             chk("R12 sig_o", sig_out, 0);
    chk(m_sync ? "R9 frac_valid" : "R8 frac_valid", frac_valid, m_v);
    if (m_v) chk(m_sync ? "R9 frac_data" : "R8 frac_data", frac_data, m_d);
  endtask

  // ben: 0 every 2nd cycle, 1 random
  task automatic run(input int n, input bit irregular);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      bit_en   = irregular ? 1'($urandom % 3 == 0) : 1'(cyc % 2 == 0);
      chan_clk = 1'($urandom);
      frac_d   = 1'($urandom);
      sig      = 1'($urandom);
      #1 compare_all();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ts_id in reset", ts_id, 0);
    chk("R1 valid in reset", frac_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ts_id after reset", ts_id, 0);
    chk("R1 valid after reset", frac_valid, 0);

    run(9000, 0);
    // mid-frame change: no visible effect yet
    run(100, 0);
    gap_en = 1'b1;
    run(1, 0);
    chk("R11 gap not yet applied", m_gap, 0);
    run(3000, 0);
    frac_en = 1'b1;
    run(9000, 0);
    frac_sync = 1'b1;
    run(3000, 0);
    hs_mode = 1'b1;
    run(3000, 0);
    hs_mode = 1'b0; frac_en = 1'b0; gap_en = 1'b0;
    run(5000, 1);
    frac_en = 1'b1; frac_sync = 1'b0;
    run(9000, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule